// File: doc/BRIEF.md
# ADC Conversion Handshake Controller

This block connects a processor-side register port to an external 8-bit analog-to-digital converter. Software starts a conversion by writing a command bit. The block then drives a one-cycle start pulse to the converter and watches the converter's end-of-conversion line. That line drops low while the conversion runs and comes back high when the result is ready. On the rising edge of the line, the block captures the converter's output into a holding register.

Software can learn that a conversion has finished in two ways. In the first, it polls a ready bit in the status register and then reads the result. In the second, it enables an interrupt request. The request is raised by the same rising edge and stays latched until software clears it, either by reading the result or by writing an explicit clear. This latching keeps one conversion from being serviced twice. The end-of-conversion input is asynchronous to the block clock, so it passes through a flop synchronizer before edge detection.

Top module: `conv_hs_top`

## Requirements
- R1: After reset, `startOut` and `irqOut` are 0, the status word reads 0 and the result register reads 0.
- R2: A write to address 0 with data bit 0 set, made while no conversion is in progress, drives `startOut` high for exactly one cycle starting at the write edge, and sets the busy flag. The busy flag reads as status bit 1 at address 0.
- R3: A start write made while busy is ignored: no further start pulse is issued.
- R4: `eocIn` passes through two synchronizer flops. The result is captured and the ready flag is set at the third rising clock edge after `eocIn` rises, and busy is cleared at that same edge. Ready reads as status bit 0 at address 0.
- R5: In polled use, once the ready bit is seen, a read of address 2 returns the converter data that was present when the conversion completed.
- R6: A read of address 2 with `regRdEn` high clears both the ready flag and the pending interrupt. The pending interrupt reads as status bit 2 at address 0.
- R7: A completed conversion always sets the pending interrupt. `irqOut` is high only while the pending interrupt is set and the enable bit is 1. The enable bit is bit 0 of address 1, which can be read and written. The enable bit gates neither the ready flag nor the pending interrupt.
- R8: The pending interrupt stays set until it is cleared. A write of data bit 0 = 1 to address 3 clears it without touching the ready flag.
- R9: A rising edge on `eocIn` while no conversion is in progress changes neither the ready flag nor the result.
- R10: If a completion and a result read fall on the same clock edge, the read returns the old result, and the ready flag and new result from the completion are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; it has side effects only at address 2 |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, a combinational decode of `regAddr` |
| startOut | output | 1 | One-cycle conversion start pulse to the converter |
| eocIn | input | 1 | End-of-conversion from the converter, asynchronous |
| convData | input | 8 | Converter result bus |
| irqOut | output | 1 | Interrupt request, level, active high |

## Verification
The assertions assume that `convData` is stable from the time `eocIn` rises until the capture edge. They also assume that `eocIn` falls after a start pulse and rises only once per conversion. The converter model in the bench keeps to both: it changes the data before it raises end-of-conversion, and it holds the data and the line steady afterwards. Cases that break the protocol, such as a spurious edge while idle or a start while busy, are driven on purpose by a direct driver that keeps the same data-before-edge ordering.

// File: rtl/conv_hs_pkg.sv
package conv_hs_pkg;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_CMD    = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_IEN    = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_RESULT = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_IRQCLR = 2'd3;

  localparam int STAT_READY_BIT = 0;
  localparam int STAT_BUSY_BIT  = 1;
  localparam int STAT_PEND_BIT  = 2;

  // strobes and flags handed from control to datapath
  typedef struct packed {
    logic captureNow;
    logic readyFlag;
    logic busyFlag;
    logic pendFlag;
    logic ienFlag;
  } ctrl_strobes_t;

endpackage

// File: rtl/conv_eoc_sync.sv
module conv_eoc_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic eocAsync,
  output logic eocRise
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   eocPrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= eocAsync;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eocPrev <= 1'b1;
    else       eocPrev <= syncChain[SYNC_STAGES-1];
  end

  assign eocRise = syncChain[SYNC_STAGES-1] & ~eocPrev;

endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_hs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrBit0,
  input  logic                  eocRise,
  output logic                  startOut,
  output logic                  irqOut,
  output ctrl_strobes_t         strobes
);

  logic startCmd, startAccept, captureNow, resultRead, irqClr, ienWrite;
  logic busy, ready, pend, ien, startPulse;

  assign startCmd    = regWrEn && (regAddr == ADDR_CMD) && wrBit0;
  assign startAccept = startCmd && !busy;
  assign captureNow  = eocRise && busy;
  assign resultRead  = regRdEn && (regAddr == ADDR_RESULT);
  assign irqClr      = regWrEn && (regAddr == ADDR_IRQCLR) && wrBit0;
  assign ienWrite    = regWrEn && (regAddr == ADDR_IEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      busy       <= 1'b0;
      ready      <= 1'b0;
      pend       <= 1'b0;
      ien        <= 1'b0;
    end else begin
      startPulse <= startAccept;
      if (startAccept)     busy <= 1'b1;
      else if (captureNow) busy <= 1'b0;
      if (captureNow)      ready <= 1'b1;
      else if (resultRead) ready <= 1'b0;
      if (captureNow)                pend <= 1'b1;
      else if (resultRead || irqClr) pend <= 1'b0;
      if (ienWrite) ien <= wrBit0;
    end
  end

  assign startOut = startPulse;
  assign irqOut   = pend & ien;

  always_comb begin
    strobes            = '0;
    strobes.captureNow = captureNow;
    strobes.readyFlag  = ready;
    strobes.busyFlag   = busy;
    strobes.pendFlag   = pend;
    strobes.ienFlag    = ien;
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    startOut |=> !startOut);
  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    startOut |-> busy);
  assert_busy_blocks_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startCmd) |=> !startOut);
  assert_ready_from_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(eocRise));
  assert_ready_cleared_by_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(resultRead));
  assert_pend_latched_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pend) |-> $past(resultRead || irqClr));
  assert_idle_edge_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eocRise && !busy && !resultRead) |=> (ready == $past(ready)));

endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         strobes,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     convData,
  output logic [DATA_W-1:0]     regRdData
);

  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] ienWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resultReg <= '0;
    else if (strobes.captureNow) resultReg <= convData;
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[STAT_READY_BIT] = strobes.readyFlag;
    statusWord[STAT_BUSY_BIT]  = strobes.busyFlag;
    statusWord[STAT_PEND_BIT]  = strobes.pendFlag;
    ienWord                    = '0;
    ienWord[0]                 = strobes.ienFlag;
  end

  always_comb begin
    case (regAddr)
      ADDR_CMD:    regRdData = statusWord;
      ADDR_IEN:    regRdData = ienWord;
      ADDR_RESULT: regRdData = resultReg;
      default:     regRdData = '0;
    endcase
  end

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureNow |=> (resultReg == $past(convData)));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureNow |=> $stable(resultReg));

endmodule

// File: rtl/conv_hs_top.sv
module conv_hs_top
  import conv_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  startOut,
  input  logic                  eocIn,
  input  logic [DATA_W-1:0]     convData,
  output logic                  irqOut
);

  logic          eocRise;
  ctrl_strobes_t strobes;

  conv_eoc_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .eocAsync (eocIn),
    .eocRise  (eocRise)
  );

  conv_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .wrBit0   (regWrData[0]),
    .eocRise  (eocRise),
    .startOut (startOut),
    .irqOut   (irqOut),
    .strobes  (strobes)
  );

  conv_datapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .convData  (convData),
    .regRdData (regRdData)
  );

endmodule

// File: tb/tb_conv_hs_top.sv
module tb_conv_hs_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, regWrEn, regRdEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  wire  [7:0] regRdData;
  wire        startOut, irqOut;
  logic       eocIn;
  logic [7:0] convData;

  logic       modelOn;
  logic       mdlEoc, manEoc;
  logic [7:0] mdlData, manData;
  int         convLat;

  assign eocIn    = modelOn ? mdlEoc  : manEoc;
  assign convData = modelOn ? mdlData : manData;

  conv_hs_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .startOut(startOut), .eocIn(eocIn), .convData(convData), .irqOut(irqOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [7:0] adcQ[$];
  logic [7:0] expQ[$];
  logic [7:0] seenVal;
  event       seenEv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic collect();
    @(negedge clk);
    regAddr = 2'd2; regRdEn = 1'b1;
    #1;
    seenVal = regRdData;
    ->seenEv;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic launch(input logic [7:0] v);
    adcQ.push_back(v);
    expQ.push_back(v);
    wrReg(2'd0, 8'h01);
  endtask

  task automatic pollReady(input string tag);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      peek(2'd0, s);
      if (s[0]) break;
    end
    chk(s[0] == 1'b1, tag, s[0], 1);
  endtask

  task automatic manualConv(input logic [7:0] v);
    wrReg(2'd0, 8'h01);
    @(negedge clk); manEoc = 1'b0;
    repeat (4) @(negedge clk);
    manData = v; manEoc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // converter model: delayed responder
  initial begin
    mdlEoc = 1'b1; mdlData = 8'h00;
    forever begin
      @(posedge clk);
      if (modelOn && startOut) begin
        repeat (2) @(posedge clk);
        #1 mdlEoc = 1'b0;
        repeat (convLat) @(posedge clk);
        #1 mdlData = adcQ.pop_front();
        @(posedge clk);
        #1 mdlEoc = 1'b1;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(seenEv);
      if (expQ.size() == 0) chk(1'b0, "R5 unexpected result", seenVal, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(seenVal == e, "R5 result value", seenVal, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r, got;
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; regAddr = 2'd0; regWrData = 8'h00;
    manEoc = 1'b1; manData = 8'h00; modelOn = 1'b1; convLat = 5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(startOut == 1'b0, "R1 startOut", startOut, 0);
    chk(irqOut == 1'b0, "R1 irqOut", irqOut, 0);
    peek(2'd0, s); chk(s == 8'h00, "R1 status", s, 0);
    peek(2'd2, r); chk(r == 8'h00, "R1 result", r, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 one-cycle start pulse, busy set
    launch(8'h3C);
    chk(startOut == 1'b1, "R2 pulse high", startOut, 1);
    peek(2'd0, s); chk(s[1] == 1'b1, "R2 busy set", s[1], 1);
    @(negedge clk);
    chk(startOut == 1'b0, "R2 pulse one cycle", startOut, 0);

    // R3 start while busy ignored
    wrReg(2'd0, 8'h01);
    chk(startOut == 1'b0, "R3 no pulse while busy", startOut, 0);
    @(negedge clk);
    chk(startOut == 1'b0, "R3 no late pulse", startOut, 0);

    // R5 polled flow
    pollReady("R5 ready seen");
    peek(2'd0, s); chk(s[1] == 1'b0, "R4 busy cleared", s[1], 0);
    collect();
    peek(2'd0, s);
    chk(s[0] == 1'b0, "R6 ready cleared by read", s[0], 0);
    chk(s[2] == 1'b0, "R6 pending cleared by read", s[2], 0);

    // R7/R8 interrupt flow
    wrReg(2'd1, 8'h01);
    peek(2'd1, s); chk(s[0] == 1'b1, "R7 enable readback", s[0], 1);
    convLat = 9;
    launch(8'hA5);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irqOut) break;
    end
    chk(irqOut == 1'b1, "R7 irq raised", irqOut, 1);
    repeat (10) @(negedge clk);
    chk(irqOut == 1'b1, "R8 irq stays latched", irqOut, 1);
    collect();
    chk(irqOut == 1'b0, "R6 irq cleared by result read", irqOut, 0);

    // R7 enable gates only the output
    wrReg(2'd1, 8'h00);
    convLat = 3;
    launch(8'h5A);
    pollReady("R7 ready with irq disabled");
    peek(2'd0, s); chk(s[2] == 1'b1, "R7 pending with irq disabled", s[2], 1);
    chk(irqOut == 1'b0, "R7 irq masked", irqOut, 0);
    wrReg(2'd1, 8'h01);
    chk(irqOut == 1'b1, "R7 irq after enable", irqOut, 1);
    wrReg(2'd3, 8'h01);
    chk(irqOut == 1'b0, "R8 irq explicit clear", irqOut, 0);
    peek(2'd0, s);
    chk(s[0] == 1'b1, "R8 ready kept by clear", s[0], 1);
    chk(s[2] == 1'b0, "R8 pending cleared", s[2], 0);
    collect();

    // R4 synchronizer latency
    modelOn = 1'b0;
    wrReg(2'd1, 8'h00);
    wrReg(2'd0, 8'h01);
    @(negedge clk); manEoc = 1'b0;
    repeat (4) @(negedge clk);
    manData = 8'h96; manEoc = 1'b1;
    @(negedge clk);
    peek(2'd0, s); chk(s[0] == 1'b0, "R4 not ready after edge 1", s[0], 0);
    @(negedge clk);
    peek(2'd0, s); chk(s[0] == 1'b0, "R4 not ready after edge 2", s[0], 0);
    @(negedge clk);
    peek(2'd0, s); chk(s[0] == 1'b1, "R4 ready after edge 3", s[0], 1);
    peek(2'd2, r); chk(r == 8'h96, "R4 captured data", r, 8'h96);
    expQ.push_back(8'h96);
    collect();

    // R9 edge while idle ignored
    @(negedge clk); manEoc = 1'b0;
    repeat (4) @(negedge clk);
    manData = 8'h11; manEoc = 1'b1;
    repeat (6) @(negedge clk);
    peek(2'd0, s); chk(s[0] == 1'b0, "R9 ready unchanged", s[0], 0);
    peek(2'd2, r); chk(r == 8'h96, "R9 result unchanged", r, 8'h96);

    // R10 completion and read on the same edge
    manualConv(8'h21);
    wrReg(2'd0, 8'h01);
    @(negedge clk); manEoc = 1'b0;
    repeat (4) @(negedge clk);
    manData = 8'h7E; manEoc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regAddr = 2'd2; regRdEn = 1'b1;
    #1 got = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
    chk(got == 8'h21, "R10 read returns old result", got, 8'h21);
    peek(2'd0, s); chk(s[0] == 1'b1, "R10 ready kept", s[0], 1);
    peek(2'd2, r); chk(r == 8'h7E, "R10 new result kept", r, 8'h7E);
    expQ.push_back(8'h7E);
    collect();

    @(negedge clk);
    chk(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule